// File: doc/BRIEF.md
# Control-transfer recording qualifier

This block sits beside a core's retire stage and decides, cycle by cycle, whether the control transfer or trap that just retired should be written into a transfer-history buffer. Each retired transfer arrives as a valid strobe together with a 4-bit kind code, the privilege mode it retired in and, for traps, the mode the trap goes to. The block checks the transfer against a 64-bit configuration word held in the CSR file. The word carries per-mode enables, trap overrides, per-kind filter bits and freeze triggers. The block then raises a registered record strobe one cycle later.

It also keeps a sticky frozen flag. A breakpoint exception or a local counter-overflow interrupt that traps to supervisor or machine mode can set the flag, depending on the configuration. While the flag is set, nothing is recorded. Only a dedicated clear input drops it. Because the flag is registered, the trap that causes the freeze is still recorded.

Top module: `ctr_qual`

## Requirements
- R1: `rec_o` is registered. It is high in the cycle after a cycle with `xfer_vld_i` high and a qualifying transfer. It is never high after a cycle without `xfer_vld_i`.
- R2: Privilege codes are U=0, S=1, M=3, and code 2 is reserved. A transfer qualifies by mode only when the enable bit for `src_priv_i` is set: `cfg_i[0]` for U, `cfg_i[1]` for S, `cfg_i[2]` for M. A reserved source mode never qualifies by mode.
- R3: For traps (kind codes 2 and 3), the mode check also passes when `trap_tgt_i` is S (1) and `cfg_i[8]` is set, or when `trap_tgt_i` is M (3) and `cfg_i[9]` is set. The override has no effect on other kinds.
- R4: Kind codes and their filter bits are listed below. A set filter bit blocks its kind.
  - 1 taken branch: `cfg_i[37]`
  - 2 exception: `cfg_i[33]`
  - 3 interrupt: `cfg_i[34]`
  - 4 trap return: `cfg_i[35]`
  - 5 indirect call: `cfg_i[40]`
  - 6 direct call: `cfg_i[41]`
  - 7 indirect jump: `cfg_i[42]`
  - 8 direct jump: `cfg_i[43]`
  - 9 co-routine swap: `cfg_i[44]`
  - 10 return: `cfg_i[45]`
  - 11 other indirect linked jump: `cfg_i[46]`
  - 12 other direct linked jump: `cfg_i[47]`
- R5: Kind 0 (not-taken branch) is recorded only when `cfg_i[36]` is set.
- R6: Kind codes 13 to 15 are never recorded.
- R7: A valid exception (kind 2) with `is_bkpt_i` high, targeting S or M, sets `frozen_o` in the next cycle when `cfg_i[11]` is set. The same trap targeting U does not set it.
- R8: A valid interrupt (kind 3) with `is_lcofi_i` high, targeting S or M, sets `frozen_o` in the next cycle when `cfg_i[12]` is set.
- R9: While `frozen_o` is high, `rec_o` stays low in the following cycle. The trap that sets the flag is itself recorded.
- R10: `frozen_o` stays high until a cycle with `frz_clr_i` high, and falls in the next cycle. A freeze trigger in the same cycle as the clear keeps the flag set.
- R11: After reset, `rec_o` and `frozen_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_vld_i | input | 1 | A transfer retired this cycle |
| xfer_type_i | input | 4 | Transfer kind code |
| src_priv_i | input | 2 | Privilege mode the transfer retired in |
| trap_tgt_i | input | 2 | Mode a trap goes to |
| is_bkpt_i | input | 1 | Exception is a breakpoint |
| is_lcofi_i | input | 1 | Interrupt is a local counter overflow |
| frz_clr_i | input | 1 | Clear the frozen flag |
| cfg_i | input | 64 | Configuration word from the CSR file |
| rec_o | output | 1 | Record strobe, one cycle after the transfer |
| frozen_o | output | 1 | Frozen flag |

## Verification
A wrong mode or kind decision appears on `rec_o` exactly one cycle after the offending transfer. For that reason every directed transfer is followed by a sample of `rec_o` in the next cycle. A stale or stuck frozen flag shows up directly on `frozen_o` in the cycle after the trigger or the clear. Its effect also shows on the next transfer, which must come out unrecorded. The bench therefore sends a qualifying transfer right after each freeze and clear.

// File: rtl/ctr_qual_pkg.sv
package ctr_qual_pkg;
  localparam int unsigned CFG_W   = 64;
  localparam int unsigned TYPE_W  = 4;
  localparam int unsigned PRIV_W  = 2;
  localparam int unsigned N_FILT  = 12;

  // bit positions of the configuration word, decoded by the CSR file too
  localparam int unsigned B_EN_U      = 0;
  localparam int unsigned B_EN_S      = 1;
  localparam int unsigned B_EN_M      = 2;
  localparam int unsigned B_TRAP_S    = 8;
  localparam int unsigned B_TRAP_M    = 9;
  localparam int unsigned B_FRZ_BKPT  = 11;
  localparam int unsigned B_FRZ_LCOFI = 12;
  localparam int unsigned B_INH_EXC   = 33;
  localparam int unsigned B_INH_INTR  = 34;
  localparam int unsigned B_INH_TRET  = 35;
  localparam int unsigned B_NTBR_EN   = 36;
  localparam int unsigned B_INH_TKBR  = 37;
  localparam int unsigned B_INH_JMP0  = 40;

  typedef enum logic [PRIV_W-1:0] {
    PRIV_U = 2'd0, PRIV_S = 2'd1, PRIV_RSV = 2'd2, PRIV_M = 2'd3
  } priv_e;

  typedef enum logic [TYPE_W-1:0] {
    XT_NTBR   = 4'd0,  XT_TKBR   = 4'd1,  XT_EXC    = 4'd2,  XT_INTR  = 4'd3,
    XT_TRET   = 4'd4,  XT_ICALL  = 4'd5,  XT_DCALL  = 4'd6,  XT_IJMP  = 4'd7,
    XT_DJMP   = 4'd8,  XT_CSWAP  = 4'd9,  XT_RET    = 4'd10, XT_ILJMP = 4'd11,
    XT_DLJMP  = 4'd12
  } xfer_e;

  typedef struct packed {
    logic en_u;
    logic en_s;
    logic en_m;
    logic trap_s;
    logic trap_m;
  } priv_cfg_t;

  // filt[k] blocks kind k+1
  typedef struct packed {
    logic              ntbr_en;
    logic [N_FILT-1:0] filt;
  } type_cfg_t;

  function automatic logic is_trap(logic [TYPE_W-1:0] t);
    return (t == XT_EXC) || (t == XT_INTR);
  endfunction
endpackage

// File: rtl/ctr_priv_gate.sv
module ctr_priv_gate
  import ctr_qual_pkg::*;
(
  input  priv_cfg_t         pcfg_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [PRIV_W-1:0] src_i,
  input  logic [PRIV_W-1:0] tgt_i,
  output logic              ok_o
);
  logic mode_ok, ovr_ok;

  always_comb begin
    case (src_i)
      PRIV_U:  mode_ok = pcfg_i.en_u;
      PRIV_S:  mode_ok = pcfg_i.en_s;
      PRIV_M:  mode_ok = pcfg_i.en_m;
      default: mode_ok = 1'b0;
    endcase
  end

  // traps may land in a mode whose recording is off
  assign ovr_ok = is_trap(type_i) &&
                  (((tgt_i == PRIV_S) && pcfg_i.trap_s) ||
                   ((tgt_i == PRIV_M) && pcfg_i.trap_m));

  assign ok_o = mode_ok | ovr_ok;
endmodule

// File: rtl/ctr_type_filter.sv
module ctr_type_filter
  import ctr_qual_pkg::*;
(
  input  type_cfg_t         tcfg_i,
  input  logic [TYPE_W-1:0] type_i,
  output logic              ok_o
);
  localparam int unsigned N_CODE = 1 << TYPE_W;

  logic [N_CODE-1:0] pass_vec;

  assign pass_vec[XT_NTBR] = tcfg_i.ntbr_en;

  for (genvar k = 1; k < N_CODE; k++) begin : g_code
    if (k <= N_FILT) begin : g_filt
      assign pass_vec[k] = ~tcfg_i.filt[k-1];
    end else begin : g_rsv
      assign pass_vec[k] = 1'b0;
    end
  end

  assign ok_o = pass_vec[type_i];
endmodule

// File: rtl/ctr_freeze.sv
module ctr_freeze
  import ctr_qual_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [PRIV_W-1:0] tgt_i,
  input  logic              bkpt_i,
  input  logic              lcofi_i,
  input  logic              frz_bkpt_i,
  input  logic              frz_lcofi_i,
  input  logic              clr_i,
  output logic              frozen_o
);
  logic tgt_hi, trig, frozen_q;

  assign tgt_hi = (tgt_i == PRIV_S) || (tgt_i == PRIV_M);
  assign trig   = vld_i && tgt_hi &&
                  (((type_i == XT_EXC)  && bkpt_i  && frz_bkpt_i) ||
                   ((type_i == XT_INTR) && lcofi_i && frz_lcofi_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frozen_q <= 1'b0;
    else if (trig)   frozen_q <= 1'b1;  // set wins over clear
    else if (clr_i)  frozen_q <= 1'b0;
  end

  assign frozen_o = frozen_q;
endmodule

// File: rtl/ctr_qual.sv
module ctr_qual
  import ctr_qual_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_vld_i,
  input  logic [TYPE_W-1:0] xfer_type_i,
  input  logic [PRIV_W-1:0] src_priv_i,
  input  logic [PRIV_W-1:0] trap_tgt_i,
  input  logic              is_bkpt_i,
  input  logic              is_lcofi_i,
  input  logic              frz_clr_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic              rec_o,
  output logic              frozen_o
);
  priv_cfg_t pcfg;
  type_cfg_t tcfg;
  logic      priv_ok, type_ok, frozen, rec_q;

  assign pcfg.en_u   = cfg_i[B_EN_U];
  assign pcfg.en_s   = cfg_i[B_EN_S];
  assign pcfg.en_m   = cfg_i[B_EN_M];
  assign pcfg.trap_s = cfg_i[B_TRAP_S];
  assign pcfg.trap_m = cfg_i[B_TRAP_M];

  assign tcfg.ntbr_en = cfg_i[B_NTBR_EN];
  assign tcfg.filt    = {cfg_i[B_INH_JMP0+7:B_INH_JMP0], cfg_i[B_INH_TRET],
                         cfg_i[B_INH_INTR], cfg_i[B_INH_EXC], cfg_i[B_INH_TKBR]};

  logic unused_cfg;
  assign unused_cfg = ^{cfg_i[CFG_W-1:B_INH_JMP0+8], cfg_i[B_INH_JMP0-1:B_INH_TKBR+1],
                        cfg_i[B_INH_EXC-1:B_FRZ_LCOFI+1], cfg_i[B_FRZ_BKPT-1],
                        cfg_i[B_TRAP_S-1:B_EN_M+1]};

  ctr_priv_gate u_priv (
    .pcfg_i (pcfg),
    .type_i (xfer_type_i),
    .src_i  (src_priv_i),
    .tgt_i  (trap_tgt_i),
    .ok_o   (priv_ok)
  );

  ctr_type_filter u_filt (
    .tcfg_i (tcfg),
    .type_i (xfer_type_i),
    .ok_o   (type_ok)
  );

  ctr_freeze u_frz (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vld_i       (xfer_vld_i),
    .type_i      (xfer_type_i),
    .tgt_i       (trap_tgt_i),
    .bkpt_i      (is_bkpt_i),
    .lcofi_i     (is_lcofi_i),
    .frz_bkpt_i  (cfg_i[B_FRZ_BKPT]),
    .frz_lcofi_i (cfg_i[B_FRZ_LCOFI]),
    .clr_i       (frz_clr_i),
    .frozen_o    (frozen)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rec_q <= 1'b0;
    else         rec_q <= xfer_vld_i && priv_ok && type_ok && !frozen;
  end

  assign rec_o    = rec_q;
  assign frozen_o = frozen;
endmodule

// File: rtl/ctr_qual_chk.sv
module ctr_qual_chk
  import ctr_qual_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              xfer_vld_i,
  input logic [TYPE_W-1:0] xfer_type_i,
  input logic [PRIV_W-1:0] src_priv_i,
  input logic [PRIV_W-1:0] trap_tgt_i,
  input logic              is_bkpt_i,
  input logic              is_lcofi_i,
  input logic              frz_clr_i,
  input logic [CFG_W-1:0]  cfg_i,
  input logic              rec_o,
  input logic              frozen_o
);
  logic unused_chk;
  assign unused_chk = ^{cfg_i, is_lcofi_i};

  a_r1_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_vld_i |=> !rec_o);

  a_r2_rsv_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_vld_i && src_priv_i == PRIV_RSV && !is_trap(xfer_type_i) |=> !rec_o);

  a_r2_u_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_vld_i && src_priv_i == PRIV_U && !cfg_i[B_EN_U] && !is_trap(xfer_type_i) |=> !rec_o);

  a_r6_bad_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_vld_i && xfer_type_i > XT_DLJMP |=> !rec_o);

  a_r7_bkpt_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_vld_i && xfer_type_i == XT_EXC && is_bkpt_i && cfg_i[B_FRZ_BKPT] &&
    (trap_tgt_i == PRIV_S || trap_tgt_i == PRIV_M) |=> frozen_o);

  a_r9_frozen_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_o |=> !rec_o);

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_o && !frz_clr_i |=> frozen_o);

  a_r10_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frozen_o) |-> $past(xfer_vld_i) && $past(is_trap(xfer_type_i)));
endmodule

bind ctr_qual ctr_qual_chk chk_i (.*);

// File: tb/ctr_qual_tb_top.sv
`timescale 1ns/1ps
module ctr_qual_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [3:0]  typ = '0;
  logic [1:0]  src = '0;
  logic [1:0]  tgt = '0;
  logic        bkpt = 1'b0;
  logic        lcofi = 1'b0;
  logic        clr = 1'b0;
  logic [63:0] cfg = '0;
  logic        rec, frozen;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ctr_qual dut_i (
    .clk_i(clk), .rst_ni(rst_n), .xfer_vld_i(vld), .xfer_type_i(typ),
    .src_priv_i(src), .trap_tgt_i(tgt), .is_bkpt_i(bkpt), .is_lcofi_i(lcofi),
    .frz_clr_i(clr), .cfg_i(cfg), .rec_o(rec), .frozen_o(frozen)
  );

  localparam logic [63:0] EN_ALL = 64'h7;

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  // drive one transfer for a cycle; returns at the next negedge
  task automatic send(logic [3:0] t, logic [1:0] s, logic [1:0] g,
                      logic b = 1'b0, logic l = 1'b0, logic c = 1'b0);
    @(negedge clk);
    vld = 1'b1; typ = t; src = s; tgt = g; bkpt = b; lcofi = l; clr = c;
    @(negedge clk);
    vld = 1'b0; bkpt = 1'b0; lcofi = 1'b0; clr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  function automatic logic model(logic [63:0] c, logic [3:0] t, logic [1:0] s, logic [1:0] g);
    logic p, k;
    p = (s == 2'd0 && c[0]) || (s == 2'd1 && c[1]) || (s == 2'd3 && c[2]);
    if (t == 4'd2 || t == 4'd3) p = p || (g == 2'd1 && c[8]) || (g == 2'd3 && c[9]);
    case (t)
      4'd0: k = c[36];
      4'd1: k = !c[37];
      4'd2: k = !c[33];
      4'd3: k = !c[34];
      4'd4: k = !c[35];
      default: k = (t <= 4'd12) ? !c[35 + int'(t)] : 1'b0;
    endcase
    return p && k;
  endfunction

  task automatic t_reset();
    chk("R11 rec", rec, 1'b0);
    chk("R11 frozen", frozen, 1'b0);
  endtask

  task automatic t_idle();
    cfg = EN_ALL | (64'h1 << 36);
    typ = 4'd6; src = 2'd3;
    @(negedge clk); @(negedge clk);
    chk("R1 idle", rec, 1'b0);
    send(4'd6, 2'd3, 2'd0);
    chk("R1 one cycle later", rec, 1'b1);
    @(negedge clk);
    chk("R1 single pulse", rec, 1'b0);
  endtask

  task automatic t_priv();
    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < 3; e++) begin
        cfg = 64'h1 << e;
        send(4'd6, 2'(m), 2'd0);
        chk($sformatf("R2 src=%0d en=%0d", m, e), rec, model(cfg, 4'd6, 2'(m), 2'd0));
      end
    end
  endtask

  task automatic t_trap_ovr();
    cfg = 64'h1 << 8;
    send(4'd2, 2'd0, 2'd1);
    chk("R3 exc to S via bit8", rec, 1'b1);
    send(4'd2, 2'd0, 2'd3);
    chk("R3 exc to M bit8 only", rec, 1'b0);
    cfg = 64'h1 << 9;
    send(4'd3, 2'd1, 2'd3);
    chk("R3 intr to M via bit9", rec, 1'b1);
    cfg = (64'h1 << 8) | (64'h1 << 9);
    send(4'd6, 2'd0, 2'd1);
    chk("R3 no effect on call", rec, 1'b0);
  endtask

  task automatic t_filter();
    for (int t = 1; t <= 12; t++) begin
      for (int own = 0; own < 2; own++) begin
        int bitpos;
        case (t)
          1: bitpos = 37; 2: bitpos = 33; 3: bitpos = 34; 4: bitpos = 35;
          default: bitpos = 35 + t;
        endcase
        if (own == 1) cfg = EN_ALL | (64'h1 << bitpos);
        else          cfg = (EN_ALL | 64'h0000_FF3E_0000_0000) & ~(64'h1 << bitpos);
        send(4'(t), 2'd1, 2'd1);
        chk($sformatf("R4 type=%0d own=%0d", t, own), rec, own == 1 ? 1'b0 : 1'b1);
      end
    end
  endtask

  task automatic t_ntbr();
    cfg = EN_ALL;
    send(4'd0, 2'd0, 2'd0);
    chk("R5 ntbr off", rec, 1'b0);
    cfg = EN_ALL | (64'h1 << 36);
    send(4'd0, 2'd0, 2'd0);
    chk("R5 ntbr on", rec, 1'b1);
  endtask

  task automatic t_badcode();
    cfg = EN_ALL | (64'h1 << 36) | (64'h3 << 8);
    for (int t = 13; t < 16; t++) begin
      send(4'(t), 2'd3, 2'd3);
      chk($sformatf("R6 code=%0d", t), rec, 1'b0);
    end
  endtask

  task automatic t_bkpt();
    cfg = EN_ALL;
    send(4'd2, 2'd0, 2'd1, 1'b1);
    chk("R7 bit11 clear no freeze", frozen, 1'b0);
    cfg = EN_ALL | (64'h1 << 11);
    send(4'd2, 2'd1, 2'd0, 1'b1);
    chk("R7 target U no freeze", frozen, 1'b0);
    send(4'd2, 2'd0, 2'd1, 1'b1);
    chk("R7 freeze set", frozen, 1'b1);
    chk("R9 trigger recorded", rec, 1'b1);
    send(4'd6, 2'd3, 2'd0);
    chk("R9 frozen blocks", rec, 1'b0);
    chk("R10 sticky", frozen, 1'b1);
    pulse_clr();
    chk("R10 cleared", frozen, 1'b0);
    send(4'd6, 2'd3, 2'd0);
    chk("R9 records after clear", rec, 1'b1);
  endtask

  task automatic t_lcofi();
    cfg = EN_ALL;
    send(4'd3, 2'd0, 2'd3, 1'b0, 1'b1);
    chk("R8 bit12 clear no freeze", frozen, 1'b0);
    cfg = EN_ALL | (64'h1 << 12);
    send(4'd3, 2'd0, 2'd3, 1'b0, 1'b1);
    chk("R8 freeze set", frozen, 1'b1);
    chk("R9 lcofi trap recorded", rec, 1'b1);
    send(4'd3, 2'd0, 2'd1, 1'b0, 1'b1, 1'b1);
    chk("R10 set beats clear", frozen, 1'b1);
    chk("R9 frozen trap unrecorded", rec, 1'b0);
    pulse_clr();
    chk("R10 clear after race", frozen, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_priv();
    t_trap_ovr();
    t_filter();
    t_ntbr();
    t_badcode();
    t_bkpt();
    t_lcofi();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end
endmodule